// File: doc/BRIEF.md
# Framed SPI Register Slave

This block is an 8-bit full-duplex SPI slave that gives a host controller write and read access to a small bank of four configuration registers. Every transfer also returns a status byte, which holds the channel error flags, the watchdog lock, the level of the enable input and the outcome of the previous transfer. The shift register passes bits straight through, so several devices can share one chip select in a chain. A command is accepted only when the frame carries a whole number of bytes. Any other length is discarded and flagged, and the flag then propagates down the chain.

The block runs from a system clock that is at least eight times faster than the serial clock. Chip select, serial clock and serial input pass through two-flop synchronizers before any edge is detected. The serial output is presented as a data bit plus an output enable, and the pad drives a high-impedance state when the enable is low.

Top module: `spi_cfg_slave`

## Requirements
- R1: Serial input is captured on the falling edge of the serial clock, and the serial output advances on its rising edge. Both directions are MSB first, and bit 7 appears after the first rising edge.
- R2: When chip select rises, the last 8 bits shifted in are executed only if the number of falling clock edges since chip select fell is 8, 16, 24 and so on. Any other count, including zero, leaves every register unchanged.
- R3: The transfer-error flag resets to 1. At each rising edge of chip select it becomes 0 for an accepted frame and 1 for a rejected frame.
- R4: From the falling edge of chip select until the first rising clock edge, the serial output equals the transfer-error flag ORed with the current serial input level.
- R5: While chip select is high, the output enable is low, and clock and data activity change no register.
- R6: A command byte with bit 7 = 1 is a write: bits 6:5 select the register and bits 4:0 are stored in it.
- R7: A command byte with bit 7 = 0 is a read of register bits 6:5. The next frame returns bit 7 = transfer-error flag, bits 6:5 = that address and bits 4:0 = the register contents, and that frame may itself carry a new command. A rejected frame cancels a pending read.
- R8: When no read is pending, the reply is the status byte: bit 7 = transfer-error flag, bit 6 = enable level, bit 5 = watchdog lock, bits 4:0 = channel error flags.
- R9: After reset, registers 0, 1 and 2 hold 00h and register 3 holds 07h. A read of register 1 returns the watchdog counter input in bits 4:3 in place of the stored bits.
- R10: In a frame longer than 8 bits, the bits received earlier reappear on the serial output 8 rising edges later, and only the final 8 bits form the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, low at chip-select transitions |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial output pad |
| chan_err | input | 5 | Per-channel error flags for the status byte |
| wd_lock | input | 1 | Watchdog lock status |
| en_level | input | 1 | Level of the enable pin |
| wd_count | input | 2 | Watchdog counter, read through register 1 |
| out_ctrl | output | 5 | Register 0 contents |
| wd_cfg | output | 5 | Register 1 stored contents |
| hw_cfg | output | 5 | Register 2 contents |
| diag_ctrl | output | 5 | Register 3 contents |

## Verification
The hardest situation to reach is a read that is pending when a rejected frame arrives. It can only be seen one frame later, when the reply is the status byte and not the register. The stimulus issues a read, follows it with a zero-length chip-select pulse, and then sends a write whose reply must be the status byte with the error bit set. A 16-bit frame checks the chained case. Its second reply byte must equal the first command byte, and only the second byte may take effect.

// File: rtl/spi_cfg_pkg.sv
// Shared constants and helpers for the framed SPI register slave.
package spi_cfg_pkg;
    localparam int FRAME_W  = 8;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 5;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int NUM_CH   = 5;
    localparam int WDC_ADDR = 1;   // register whose bits 4:3 read the counter

    typedef logic [DATA_W-1:0]  reg_word_t;
    typedef logic [FRAME_W-1:0] frame_t;

    // Reset value of each register after a write-side reset
    function automatic reg_word_t wr_default(input int idx);
        return (idx == NUM_REGS - 1) ? reg_word_t'(7) : reg_word_t'(0);
    endfunction
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for asynchronous serial pins.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module spi_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d_in;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_unit.sv
// Serial framing engine: edge detection, shift register, bit counting and
// serial output. Assumes synchronized inputs and SCLK low at CS transitions.
// One shift register both captures SI and supplies SO, giving pass-through.
module spi_frame_unit
    import spi_cfg_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_s,
    input  logic          si_s,
    input  logic [FW-1:0] tx_byte,
    input  logic          ter_flag,
    output logic          so,
    output logic          so_oe,
    output logic          commit,
    output logic          reject,
    output logic [FW-1:0] cmd
);
    localparam int CW = $clog2(FW);

    logic          cs_d, sclk_d;
    logic          active, pre_win, full, so_q;
    logic [CW-1:0] cnt;
    logic [FW-1:0] shreg;
    logic          cs_fall, cs_rise, sck_rise, sck_fall, whole;

    // Purpose: delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = ~cs_d & cs_s;
    assign sck_rise = active & ~sclk_d & sclk_s;
    assign sck_fall = active & sclk_d & ~sclk_s;
    assign whole    = full && (cnt == '0);

    // Purpose: frame state, shift register and output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pre_win <= 1'b0;
            full    <= 1'b0;
            so_q    <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
        end else if (cs_fall) begin
            active  <= 1'b1;
            pre_win <= 1'b1;
            full    <= 1'b0;
            so_q    <= 1'b0;
            cnt     <= '0;
            shreg   <= tx_byte;
        end else if (cs_rise) begin
            active  <= 1'b0;
            pre_win <= 1'b0;
        end else begin
            if (sck_rise) begin
                so_q    <= shreg[FW-1];
                pre_win <= 1'b0;
            end
            if (sck_fall) begin
                shreg <= {shreg[FW-2:0], si_s};
                cnt   <= cnt + 1'b1;
                if (cnt == CW'(FW-1))
                    full <= 1'b1;
            end
        end
    end

    assign commit = cs_rise & active & whole;
    assign reject = cs_rise & active & ~whole;
    assign cmd    = shreg;
    assign so_oe  = active;
    assign so     = active & (pre_win ? (ter_flag | si_s) : so_q);
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank and command decoder. Assumes a one-cycle commit or reject
// pulse with the command byte valid in that cycle. Holds the transfer-error
// flag and the pending-read state, and builds the next reply byte.
module spi_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS,
    parameter int FW = FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               reject,
    input  logic [FW-1:0]      cmd,
    input  logic [DW-1:0]      chan_err,
    input  logic               wd_lock,
    input  logic               en_level,
    input  logic [1:0]         wd_count,
    output logic [NR-1:0][DW-1:0] reg_q,
    output logic [FW-1:0]      tx_byte,
    output logic               ter_flag
);
    logic          is_write;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          rd_pend;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    assign is_write = cmd[FW-1];
    assign cmd_addr = cmd[FW-2 -: AW];
    assign cmd_data = cmd[DW-1:0];

    genvar g;
    generate
        for (g = 0; g < NR; g++) begin : g_reg
            // Purpose: one addressed register, written by an accepted write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reg_q[g] <= wr_default(g);
                else if (commit && is_write && cmd_addr == AW'(g))
                    reg_q[g] <= cmd_data;
            end
        end
    endgenerate

    // Purpose: transfer-error flag and pending-read bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ter_flag <= 1'b1;
            rd_pend  <= 1'b0;
            rd_addr  <= '0;
        end else if (commit) begin
            ter_flag <= 1'b0;
            rd_pend  <= ~is_write;
            rd_addr  <= cmd_addr;
        end else if (reject) begin
            ter_flag <= 1'b1;
            rd_pend  <= 1'b0;
        end
    end

    // Purpose: read value with the counter overlay on its register
    always_comb begin
        rd_data = reg_q[rd_addr];
        if (rd_addr == AW'(WDC_ADDR))
            rd_data[DW-1 -: 2] = wd_count;
    end

    // Purpose: choose register reply or status byte for the next frame
    always_comb begin
        if (rd_pend)
            tx_byte = {ter_flag, rd_addr, rd_data};
        else
            tx_byte = {ter_flag, en_level, wd_lock, chan_err};
    end
endmodule

// File: rtl/spi_cfg_slave.sv
// Top level of the framed SPI register slave. Synchronizes the pins,
// runs the framing engine and the register bank, exposes the registers.
// Assumes clk runs at least 8x the serial clock.
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic [NUM_CH-1:0] chan_err,
    input  logic              wd_lock,
    input  logic              en_level,
    input  logic [1:0]        wd_count,
    output logic [DATA_W-1:0] out_ctrl,
    output logic [DATA_W-1:0] wd_cfg,
    output logic [DATA_W-1:0] hw_cfg,
    output logic [DATA_W-1:0] diag_ctrl
);
    logic [2:0]                       pins_s;
    logic                             commit, reject, ter_flag;
    logic [FRAME_W-1:0]               cmd, tx_byte;
    logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_cs_n, spi_sclk, spi_si}),
        .q_out (pins_s)
    );

    spi_frame_unit #(.FW(FRAME_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .si_s     (pins_s[0]),
        .tx_byte  (tx_byte),
        .ter_flag (ter_flag),
        .so       (spi_so),
        .so_oe    (spi_so_oe),
        .commit   (commit),
        .reject   (reject),
        .cmd      (cmd)
    );

    spi_reg_bank #(.AW(ADDR_W), .DW(DATA_W), .NR(NUM_REGS), .FW(FRAME_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .reject   (reject),
        .cmd      (cmd),
        .chan_err (chan_err),
        .wd_lock  (wd_lock),
        .en_level (en_level),
        .wd_count (wd_count),
        .reg_q    (reg_q),
        .tx_byte  (tx_byte),
        .ter_flag (ter_flag)
    );

    assign out_ctrl  = reg_q[0];
    assign wd_cfg    = reg_q[1];
    assign hw_cfg    = reg_q[2];
    assign diag_ctrl = reg_q[3];
endmodule

// File: rtl/spi_cfg_checker.sv
// Property checker for spi_cfg_slave, attached by bind. Counts how long
// chip select has held its level so that sync latency is not restated.
module spi_cfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_so_oe,
    input logic [4:0] out_ctrl,
    input logic [4:0] wd_cfg,
    input logic [4:0] hw_cfg,
    input logic [4:0] diag_ctrl,
    input logic       ter_flag
);
    logic [2:0] hi_cnt, lo_cnt;
    logic [19:0] regs_now;

    assign regs_now = {diag_ctrl, hw_cfg, wd_cfg, out_ctrl};

    // Purpose: saturating run-length counters of the raw chip-select level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= spi_cs_n  ? ((hi_cnt == 3'd7) ? hi_cnt : hi_cnt + 3'd1) : 3'd0;
            lo_cnt <= !spi_cs_n ? ((lo_cnt == 3'd7) ? lo_cnt : lo_cnt + 3'd1) : 3'd0;
        end
    end

    AST_IDLE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 3'd4) |-> !spi_so_oe); // R5
    AST_SELECT_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_cnt >= 3'd4) |-> spi_so_oe); // R5
    AST_IDLE_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 3'd4) |=> $stable(regs_now)); // R2
    AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_ctrl != $past(out_ctrl), wd_cfg != $past(wd_cfg),
                    hw_cfg != $past(hw_cfg), diag_ctrl != $past(diag_ctrl)}) <= 1); // R6
    AST_TER_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ter_flag); // R3
    AST_DEFAULTS_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_ctrl == 5'h00 && hw_cfg == 5'h00 && diag_ctrl == 5'h07)); // R9
endmodule

bind spi_cfg_slave spi_cfg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_so_oe (spi_so_oe),
    .out_ctrl  (out_ctrl),
    .wd_cfg    (wd_cfg),
    .hw_cfg    (hw_cfg),
    .diag_ctrl (diag_ctrl),
    .ter_flag  (ter_flag)
);

// File: tb/tb_spi_cfg_slave.sv
// Scoreboard bench: frames push expected reply bytes, a monitor compares
// every byte observed on the serial output against the queue.
module tb_spi_cfg_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
    logic so, so_oe;
    logic [4:0] chan_err = 5'h0A;
    logic wd_lock = 1'b0, en_level = 1'b1;
    logic [1:0] wd_count = 2'b11;
    logic [4:0] out_ctrl, wd_cfg, hw_cfg, diag_ctrl;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #5 clk = ~clk;

    spi_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .chan_err(chan_err), .wd_lock(wd_lock),
        .en_level(en_level), .wd_count(wd_count), .out_ctrl(out_ctrl),
        .wd_cfg(wd_cfg), .hw_cfg(hw_cfg), .diag_ctrl(diag_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // Monitor: compare each observed reply byte with the scoreboard
    always @(negedge clk) begin
        while (obs_q.size() > 0) begin
            logic [7:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1: actual %02h expected none", o);
            end else begin
                check(tag_q.pop_front(), o, exp_q.pop_front());
            end
        end
    end

    // Frame driver: nbits MSB first, returns the pre-window SO level
    task automatic xfer(input int nbits, input logic [23:0] data, input logic pre_si,
                        output logic pre_so);
        logic [7:0] acc = '0;
        si = pre_si;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(8);
        pre_so = so;
        for (int i = nbits - 1; i >= 0; i--) begin
            si = data[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(8);
            acc = {acc[6:0], so};
            if (((nbits - 1 - i) % 8) == 7) obs_q.push_back(acc);
            sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic p;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R9 and R5: reset state
        check("R9 out_ctrl", {3'b0, out_ctrl}, 8'h00);
        check("R9 wd_cfg", {3'b0, wd_cfg}, 8'h00);
        check("R9 hw_cfg", {3'b0, hw_cfg}, 8'h00);
        check("R9 diag_ctrl", {3'b0, diag_ctrl}, 8'h07);
        check("R5 oe idle", {7'b0, so_oe}, 8'h00);

        // R3: error flag 1 after reset; R6 write reg0
        expect_byte(8'hCA, "R8 status after reset");
        xfer(8, 24'h95, 1'b0, p);
        check("R3 pre after reset", {7'b0, p}, 8'h01);
        check("R6 write reg0", {3'b0, out_ctrl}, 8'h15);

        // R7 read reg1 issued; R8 status with error clear
        expect_byte(8'h4A, "R8 status");
        xfer(8, 24'h20, 1'b0, p);
        check("R3 pre cleared", {7'b0, p}, 8'h00);

        // R7/R9 reply for reg1 with counter overlay, new read of reg3
        expect_byte(8'h38, "R9 reg1 overlay");
        xfer(8, 24'h60, 1'b0, p);

        // R7 reply reg3 while writing reg2
        expect_byte(8'h67, "R7 reg3 reply");
        xfer(8, 24'hCC, 1'b0, p);
        check("R6 write reg2", {3'b0, hw_cfg}, 8'h0C);

        // R2: 7-bit frame ignored (no byte reply expected)
        xfer(7, 24'h5F, 1'b0, p);
        check("R2 short frame ignored", {3'b0, hw_cfg}, 8'h0C);

        // R3 error after bad frame; issue read of reg2
        expect_byte(8'hCA, "R3 status after reject");
        xfer(8, 24'h40, 1'b0, p);
        check("R3 pre after reject", {7'b0, p}, 8'h01);

        // R2: zero-length frame cancels pending read (R7)
        xfer(0, 24'h0, 1'b0, p);
        expect_byte(8'hCA, "R7 read cancelled");
        xfer(8, 24'hE2, 1'b0, p);
        check("R6 write reg3", {3'b0, diag_ctrl}, 8'h02);

        // R4 pre-window OR with SI; R10 16-bit pass-through
        expect_byte(8'h4A, "R10 first byte status");
        expect_byte(8'h81, "R10 passthrough");
        xfer(16, 24'h819E, 1'b1, p);
        check("R4 pre is TER or SI", {7'b0, p}, 8'h01);
        check("R10 last byte wins", {3'b0, out_ctrl}, 8'h1E);

        // R5: clock and data activity with chip select high
        for (int k = 0; k < 10; k++) begin
            si = k[0];
            sclk = ~sclk;
            wait_clk(6);
            check("R5 oe low while idle", {7'b0, so_oe}, 8'h00);
        end
        sclk = 1'b0;
        wait_clk(6);
        check("R5 regs untouched", {3'b0, out_ctrl}, 8'h1E);
        check("R5 hw untouched", {3'b0, hw_cfg}, 8'h0C);

        // R8/R7: read reg0, then reply on next frame
        expect_byte(8'h4A, "R8 status after idle");
        xfer(8, 24'h00, 1'b0, p);
        check("R4 pre with SI low", {7'b0, p}, 8'h00);
        expect_byte(8'h1E, "R7 reg0 reply");
        xfer(8, 24'h00, 1'b0, p);

        wait_clk(10);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R1: actual %0d bytes pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule